// File: doc/BRIEF.md
# Current Threshold Comparator with Accumulator

This block watches a stream of signed current samples, each announced by a one-cycle valid strobe. It has two independent monitors.

The first monitor counts samples that lie strictly above a programmable signed threshold. A sample at or below the threshold either steps the count down by one or clears it, depending on a mode input. A sticky alarm is raised once the count reaches a programmable 8-bit limit.

The second monitor keeps a saturating signed running sum of the samples. It raises a sticky alarm when the magnitude of the sum exceeds a programmable unsigned threshold.

Both alarms are combined into one interrupt line. Dropping a monitor's enable clears that monitor. A restart strobe clears both monitors, as a host does when it reconfigures the converter that feeds the samples.

Top module: `cur_thresh_acc`

## Requirements
- R1: After reset, `hit_count`, `acc_sum`, `cmp_alarm`, `acc_alarm` and `irq` are all zero.
- R2: With `cmp_enable` high, each valid sample that is above `cmp_level` (signed two's-complement compare) adds one to `hit_count`. The count saturates at 255.
- R3: A sample exactly equal to `cmp_level` is handled as not above it.
- R4: A valid sample that is not above `cmp_level` acts on `hit_count` according to `clear_mode`. When `clear_mode` is 0, the count drops by one and saturates at 0. When `clear_mode` is 1, the count is set to 0.
- R5: `cmp_alarm` is set by a valid sample after which `hit_count` >= `hit_limit`. It then stays set, whatever later samples do, until `cmp_enable` is low or `restart` is high.
- R6: While `cmp_enable` is low, `hit_count` and `cmp_alarm` are held at zero and samples have no effect on them.
- R7: With `acc_enable` high, each valid sample is sign-extended and added to `acc_sum`. The sum saturates at 0x7FFFFFFF and at 0x80000000 instead of wrapping.
- R8: `acc_alarm` is set when the magnitude of the updated sum is strictly greater than `acc_level` (unsigned). A magnitude equal to `acc_level` does not set it, and the magnitude of 0x80000000 counts as 2^31. Once set, the alarm stays set until `acc_enable` is low or `restart` is high.
- R9: While `acc_enable` is low, `acc_sum` and `acc_alarm` are held at zero.
- R10: `irq` is high exactly while `cmp_alarm` or `acc_alarm` is high.
- R11: `restart` clears `hit_count`, `acc_sum` and both alarms at the next clock edge. It takes priority over a valid sample in the same cycle.
- R12: In a cycle with `smp_valid` low, neither the count nor the sum nor any alarm changes.
- All outputs are registered: a sample presented at a clock edge is reflected on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Clears both monitors (reconfiguration) |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed current sample |
| cmp_enable | input | 1 | Enables the threshold counter |
| cmp_level | input | 16 | Signed count threshold |
| hit_limit | input | 8 | Count at which `cmp_alarm` is set |
| clear_mode | input | 1 | 0: step down, 1: clear on a sample not above the threshold |
| acc_enable | input | 1 | Enables the accumulator |
| acc_level | input | 32 | Unsigned magnitude threshold for the sum |
| hit_count | output | 8 | Current above-threshold count |
| cmp_alarm | output | 1 | Count alarm |
| acc_sum | output | 32 | Signed running sum |
| acc_alarm | output | 1 | Sum magnitude alarm |
| irq | output | 1 | Interrupt, OR of the alarms |

## Verification
The hardest states to reach from the ports are the two saturation rails of the 32-bit sum.

Reaching them takes more than 65,000 full-scale samples in one direction. The stimulus drives long runs of +32767 and, after a restart, of -32768 until the sum pins. At the negative rail, the magnitude threshold is set to 0x7FFFFFFF so that only the 2^31 magnitude trips the alarm.

Count saturation at 255 is reached the same way with a run of 260 above-threshold samples. The equality edges of both thresholds are hit with exact sample values.

// File: rtl/cta_pkg.sv
package cta_pkg;
    localparam int unsigned SMP_W_DEF = 16;
    localparam int unsigned CNT_W_DEF = 8;
    localparam int unsigned SUM_W_DEF = 32;

    // Handling of a sample that is not above the count threshold
    typedef enum logic {
        BELOW_STEP  = 1'b0,
        BELOW_CLEAR = 1'b1
    } below_mode_e;
endpackage

// File: rtl/cta_hit_counter.sv
module cta_hit_counter
    import cta_pkg::*;
#(
    parameter int unsigned SMP_W = SMP_W_DEF,
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             enable,
    input  logic             clear_mode,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [SMP_W-1:0] level,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             alarm
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             alarm;
    } hit_state_t;

    hit_state_t  st_d, st_q;
    logic        above;
    below_mode_e mode;

    assign above = $signed(smp_data) > $signed(level);
    assign mode  = below_mode_e'(clear_mode);

    always_comb begin
        st_d = st_q;
        if (restart || !enable) begin
            st_d = '0;
        end else if (smp_valid) begin
            if (above) begin
                if (st_q.cnt != CNT_TOP) st_d.cnt = st_q.cnt + 1'b1;
            end else if (mode == BELOW_CLEAR) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            if (st_d.cnt >= limit) st_d.alarm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign alarm = st_q.alarm;
endmodule

// File: rtl/cta_sum_monitor.sv
module cta_sum_monitor
    import cta_pkg::*;
#(
    parameter int unsigned SMP_W = SMP_W_DEF,
    parameter int unsigned SUM_W = SUM_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             enable,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [SUM_W-1:0] level,
    output logic [SUM_W-1:0] sum,
    output logic             alarm
);
    localparam int unsigned EXT_W = SUM_W + 1;
    localparam int unsigned PAD_W = EXT_W - SMP_W;
    localparam logic [SUM_W-1:0] POS_RAIL = {1'b0, {(SUM_W-1){1'b1}}};
    localparam logic [SUM_W-1:0] NEG_RAIL = {1'b1, {(SUM_W-1){1'b0}}};

    typedef struct packed {
        logic [SUM_W-1:0] sum;
        logic             alarm;
    } sum_state_t;

    sum_state_t       st_d, st_q;
    logic [EXT_W-1:0] wide_sum;
    logic [SUM_W-1:0] next_sum;
    logic [EXT_W-1:0] next_ext;
    logic [EXT_W-1:0] magnitude;

    // One guard bit catches overflow of the sign-extended addition
    assign wide_sum = {st_q.sum[SUM_W-1], st_q.sum}
                    + {{PAD_W{smp_data[SMP_W-1]}}, smp_data};

    always_comb begin
        if (wide_sum[EXT_W-1] != wide_sum[EXT_W-2])
            next_sum = wide_sum[EXT_W-1] ? NEG_RAIL : POS_RAIL;
        else
            next_sum = wide_sum[SUM_W-1:0];
    end

    assign next_ext  = {next_sum[SUM_W-1], next_sum};
    assign magnitude = next_sum[SUM_W-1] ? (~next_ext + 1'b1) : next_ext;

    always_comb begin
        st_d = st_q;
        if (restart || !enable) begin
            st_d = '0;
        end else if (smp_valid) begin
            st_d.sum = next_sum;
            if (magnitude > {1'b0, level}) st_d.alarm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum   = st_q.sum;
    assign alarm = st_q.alarm;
endmodule

// File: rtl/cur_thresh_acc.sv
module cur_thresh_acc
    import cta_pkg::*;
#(
    parameter int unsigned SMP_W = SMP_W_DEF,
    parameter int unsigned CNT_W = CNT_W_DEF,
    parameter int unsigned SUM_W = SUM_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             cmp_enable,
    input  logic [SMP_W-1:0] cmp_level,
    input  logic [CNT_W-1:0] hit_limit,
    input  logic             clear_mode,
    input  logic             acc_enable,
    input  logic [SUM_W-1:0] acc_level,
    output logic [CNT_W-1:0] hit_count,
    output logic             cmp_alarm,
    output logic [SUM_W-1:0] acc_sum,
    output logic             acc_alarm,
    output logic             irq
);
    cta_hit_counter #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_hits (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .enable     (cmp_enable),
        .clear_mode (clear_mode),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .level      (cmp_level),
        .limit      (hit_limit),
        .count      (hit_count),
        .alarm      (cmp_alarm)
    );

    cta_sum_monitor #(.SMP_W(SMP_W), .SUM_W(SUM_W)) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .enable    (acc_enable),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .level     (acc_level),
        .sum       (acc_sum),
        .alarm     (acc_alarm)
    );

    // Alarms are already forced low while their monitor is disabled
    assign irq = cmp_alarm | acc_alarm;
endmodule

// File: rtl/cta_checker.sv
module cta_checker #(
    parameter int unsigned SMP_W = 16,
    parameter int unsigned CNT_W = 8,
    parameter int unsigned SUM_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             smp_valid,
    input logic [SMP_W-1:0] smp_data,
    input logic             cmp_enable,
    input logic [SMP_W-1:0] cmp_level,
    input logic             clear_mode,
    input logic             acc_enable,
    input logic [CNT_W-1:0] hit_count,
    input logic             cmp_alarm,
    input logic [SUM_W-1:0] acc_sum,
    input logic             acc_alarm,
    input logic             irq
);
    logic above;
    assign above = $signed(smp_data) > $signed(cmp_level);

    p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && cmp_enable && !restart && above |=>
        hit_count == (($past(hit_count) == {CNT_W{1'b1}}) ? $past(hit_count)
                                                          : $past(hit_count) + 1'b1));

    p_clear_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && cmp_enable && !restart && !above && clear_mode |=> hit_count == '0);

    p_cmp_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_alarm && cmp_enable && !restart |=> cmp_alarm);

    p_cmp_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_enable |=> hit_count == '0 && !cmp_alarm);

    p_acc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_alarm && acc_enable && !restart |=> acc_alarm);

    p_acc_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_enable |=> acc_sum == '0 && !acc_alarm);

    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $rose(cmp_alarm) || $rose(acc_alarm));

    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> hit_count == '0 && acc_sum == '0 && !cmp_alarm && !acc_alarm);

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid && !restart && cmp_enable && acc_enable |=>
        $stable(hit_count) && $stable(acc_sum) && $stable(cmp_alarm) && $stable(acc_alarm));
endmodule

bind cur_thresh_acc cta_checker #(.SMP_W(SMP_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_chk (.*);

// File: tb/cur_thresh_acc_tb.sv
module cur_thresh_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        cmp_enable = 1'b0;
    logic [15:0] cmp_level = '0;
    logic [7:0]  hit_limit = '0;
    logic        clear_mode = 1'b0;
    logic        acc_enable = 1'b0;
    logic [31:0] acc_level = '0;
    logic [7:0]  hit_count;
    logic        cmp_alarm;
    logic [31:0] acc_sum;
    logic        acc_alarm;
    logic        irq;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // Behavioural reference state
    int     m_cnt = 0;
    bit     m_cf = 0;
    longint m_sum = 0;
    bit     m_af = 0;

    always #5 clk = ~clk;

    cur_thresh_acc dut_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .smp_valid(smp_valid),
        .smp_data(smp_data), .cmp_enable(cmp_enable), .cmp_level(cmp_level),
        .hit_limit(hit_limit), .clear_mode(clear_mode), .acc_enable(acc_enable),
        .acc_level(acc_level), .hit_count(hit_count), .cmp_alarm(cmp_alarm),
        .acc_sum(acc_sum), .acc_alarm(acc_alarm), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model, updated at each clock edge from the inputs driven at the falling edge
    always @(posedge clk) begin
        if (!rst_n || restart) begin
            m_cnt = 0; m_cf = 0; m_sum = 0; m_af = 0;
        end else begin
            if (!cmp_enable) begin
                m_cnt = 0; m_cf = 0;
            end else if (smp_valid) begin
                if (int'($signed(smp_data)) > int'($signed(cmp_level))) begin
                    if (m_cnt < 255) m_cnt++;
                end else if (clear_mode) m_cnt = 0;
                else if (m_cnt > 0) m_cnt--;
                if (m_cnt >= int'(hit_limit)) m_cf = 1;
            end
            if (!acc_enable) begin
                m_sum = 0; m_af = 0;
            end else if (smp_valid) begin
                m_sum = m_sum + longint'($signed(smp_data));
                if (m_sum > 64'sd2147483647)  m_sum = 64'sd2147483647;
                if (m_sum < -64'sd2147483648) m_sum = -64'sd2147483648;
                if ((m_sum < 0 ? -m_sum : m_sum) > longint'(acc_level)) m_af = 1;
            end
        end
        #1;
        if (rst_n) begin
            check(int'(hit_count) == m_cnt, "R2/R4 count", longint'(hit_count), longint'(m_cnt));
            check(cmp_alarm == m_cf, "R5 cmp_alarm", longint'(cmp_alarm), longint'(m_cf));
            check(longint'($signed(acc_sum)) == m_sum, "R7 acc_sum",
                  longint'($signed(acc_sum)), m_sum);
            check(acc_alarm == m_af, "R8 acc_alarm", longint'(acc_alarm), longint'(m_af));
            check(irq == (m_cf | m_af), "R10 irq", longint'(irq), longint'(m_cf | m_af));
        end
    end

    task automatic send(input int value);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 16'(value);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic burst(input int value, input int n);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 16'(value);
        repeat (n) @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic pulse_restart(input bit with_sample);
        @(negedge clk);
        restart   = 1'b1;
        smp_valid = with_sample;
        smp_data  = 16'd300;
        @(negedge clk);
        restart   = 1'b0;
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(hit_count == 0 && acc_sum == 0 && !cmp_alarm && !acc_alarm && !irq,
              "R1 reset", longint'(hit_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_enable = 1; cmp_level = 16'd100; hit_limit = 8'd3; clear_mode = 0;
        acc_enable = 1; acc_level = 32'd1000;

        send(150);
        check(hit_count == 1, "R2 above increments", longint'(hit_count), 1);
        send(100);
        check(hit_count == 0, "R3 equal not above", longint'(hit_count), 0);
        send(150); send(150);
        check(!cmp_alarm, "R5 below limit", longint'(cmp_alarm), 0);
        send(150);
        check(hit_count == 3 && cmp_alarm, "R5 limit reached", longint'(hit_count), 3);
        check(irq, "R10 irq from count", longint'(irq), 1);
        send(50);
        check(hit_count == 2 && cmp_alarm, "R4 step down, R5 sticky", longint'(hit_count), 2);
        repeat (4) @(negedge clk);
        check(hit_count == 2 && acc_sum == 750, "R12 idle hold", longint'(acc_sum), 750);
        send(250);
        check(acc_sum == 1000 && !acc_alarm, "R8 equal magnitude", longint'(acc_alarm), 0);
        send(1);
        check(acc_alarm, "R8 exceed magnitude", longint'(acc_alarm), 1);
        clear_mode = 1;
        send(-5);
        check(hit_count == 0, "R4 clear mode", longint'(hit_count), 0);
        check(acc_alarm && acc_sum == 996, "R8 sticky", longint'(acc_sum), 996);
        cmp_enable = 0;
        send(200);
        check(hit_count == 0 && !cmp_alarm, "R6 disabled counter", longint'(hit_count), 0);
        @(negedge clk); acc_enable = 0;
        @(negedge clk);
        check(acc_sum == 0 && !acc_alarm, "R9 disabled sum", longint'(acc_sum), 0);
        check(!irq, "R10 irq low", longint'(irq), 0);
        cmp_enable = 1; acc_enable = 1; clear_mode = 0; hit_limit = 8'd2;
        send(300); send(300);
        check(cmp_alarm && acc_sum == 600, "R5 alarm before restart", longint'(acc_sum), 600);
        pulse_restart(1'b1);
        check(hit_count == 0 && acc_sum == 0 && !cmp_alarm && !acc_alarm,
              "R11 restart priority", longint'(acc_sum), 0);

        cmp_level = 16'hFFF6; // -10
        send(-5);
        check(hit_count == 1, "R2 signed compare", longint'(hit_count), 1);
        send(-20);
        check(hit_count == 0, "R4 signed below", longint'(hit_count), 0);

        cmp_level = 16'd0; hit_limit = 8'd255; acc_enable = 0;
        burst(1000, 260);
        check(hit_count == 255 && cmp_alarm, "R2 saturate 255", longint'(hit_count), 255);
        cmp_level = 16'h7FFF;
        send(0);
        check(hit_count == 254, "R4 step from 255", longint'(hit_count), 254);

        cmp_enable = 0; acc_enable = 1; acc_level = 32'hFFFF_FFFF;
        burst(32767, 65540);
        check(acc_sum == 32'h7FFF_FFFF && !acc_alarm, "R7 positive rail",
              longint'(acc_sum), 64'h7FFF_FFFF);
        pulse_restart(1'b0);
        acc_level = 32'h7FFF_FFFF;
        burst(-32768, 65540);
        check(acc_sum == 32'h8000_0000, "R7 negative rail", longint'(acc_sum), 64'h8000_0000);
        check(acc_alarm, "R8 magnitude of most negative", longint'(acc_alarm), 1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule